// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated output from an 8-bit up-counter that steps on a one-cycle clock-enable strobe. Software sets the period, the duty value, the output polarity and an enable through a small register port with four addresses. It can also restart the counter. The counter counts from zero up to period minus one and then returns to zero. The output level depends on whether the count is still below the active duty value.

Period and duty writes first go into a shadow buffer. While the channel runs, the buffered values move into the active compare latches at only three safe points: the end of a period, a counter write, or the channel being disabled. Because of this, every period shows either the old waveform or the new one and never a mix of the two. While the channel is disabled, the active latches follow the buffers directly, so writes take effect at once. Reads of period and duty return the buffer contents.

A two-state controller sequences the channel. ST_IDLE holds the counter at zero and shows the polarity level on the output. ST_RUN counts and compares. The transition T_ENABLE (a control write with the enable bit set) moves ST_IDLE to ST_RUN. The transition T_DISABLE (a control write with the enable bit clear) moves ST_RUN to ST_IDLE. Every other event keeps the current state.

Top module: `dbuf_pwm_channel`

## Requirements
- R1: After reset every register reads zero, the channel is in ST_IDLE and the output is low.
- R2: Address 0 is control (bit 0 enable, bit 1 polarity), address 1 is period, address 2 is duty, address 3 is the counter. A read of address 0 returns {polarity, running}, a read of addresses 1 or 2 returns the last value written, and a read of address 3 returns the counter.
- R3: In ST_RUN, a period or duty write changes only the buffer. The active waveform is unchanged until a load point.
- R4: In ST_RUN each tick advances the counter by one. A tick at count period−1 (or any tick when the active period is 0) returns the counter to 0 and loads both buffers into the active latches.
- R5: A write to address 3 sets the counter to 0 on the next cycle and loads both buffers into the active latches, whatever data is written.
- R6: A disabling control write loads both buffers into the active latches. In ST_IDLE the counter stays at 0 and period and duty writes take effect on the next cycle.
- R7: With polarity 1 in ST_RUN, the output is high while the counter is below the active duty and low otherwise, so the duty value is the high time in ticks.
- R8: With polarity 0 in ST_RUN, the output is low while the counter is below the active duty and high otherwise, so the high time is period − duty.
- R9: In ST_IDLE the output equals the polarity bit.
- R10: A duty of 0 gives a constant level for the whole period (low with polarity 1). A duty at or above the period gives the opposite constant level.
- R11: Without a tick, the counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong internal state shows up at the ports within one clock. A stray counter value appears on a read of address 3 and moves the pwm_out edge. A latch loaded at the wrong moment changes the high time of the period that is running, so a behavioural model of the counter, buffers and latches is compared against rdata and pwm_out on every cycle. Directed sequences also count the high cycles in whole periods around each load point, around polarity changes and around a disable, so any waveform that mixes old and new values shows up as a wrong count.

// File: rtl/dbuf_pwm_pkg.sv
`timescale 1ns/1ps
package dbuf_pwm_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_DUTY   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;

    localparam int NUM_SHADOW = 2;
    localparam int IDX_PERIOD = 0;
    localparam int IDX_DUTY   = 1;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_POL_BIT = 1;

endpackage

// File: rtl/pwm_shadow_reg.sv
`timescale 1ns/1ps
// Buffer plus active latch for one compare value.
module pwm_shadow_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wdata,
    input  logic             load,
    output logic [WIDTH-1:0] buf_q,
    output logic [WIDTH-1:0] act_q
);

    logic [WIDTH-1:0] buf_next;

    always_comb begin
        buf_next = wr_stb ? wdata : buf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            buf_q <= buf_next;
            if (load) begin
                act_q <= buf_next;
            end
        end
    end

    // R2: the buffer keeps the last written value
    p_buffer_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (buf_q == $past(wdata)));

endmodule

// File: rtl/pwm_period_counter.sv
`timescale 1ns/1ps
// Up-counter with wrap at period-1.
module pwm_period_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] cnt_q,
    output logic             wrap
);

    logic [WIDTH:0] cnt_plus;

    always_comb begin
        cnt_plus = {1'b0, cnt_q} + {{WIDTH{1'b0}}, 1'b1};
        wrap     = advance && (cnt_plus >= {1'b0, period});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || wrap) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_plus[WIDTH-1:0];
        end
    end

    // R4: the count never reaches the active period
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (cnt_q < period));

    // R11: no tick and no clear leaves the count alone
    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_level_compare.sv
`timescale 1ns/1ps
// Output level from count, duty, polarity and run state.
module pwm_level_compare #(
    parameter int WIDTH = 8
) (
    input  logic             running,
    input  logic             polarity,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] duty,
    output logic             level
);

    logic before_match;

    always_comb begin
        before_match = (cnt < duty);
        if (!running) begin
            level = polarity;
        end else if (polarity) begin
            level = before_match;
        end else begin
            level = !before_match;
        end
    end

endmodule

// File: rtl/dbuf_pwm_channel.sv
`timescale 1ns/1ps
module dbuf_pwm_channel #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             pwm_out
);
    import dbuf_pwm_pkg::*;

    chan_state_e      state_q, state_d;
    logic             pol_q;
    logic             wr_ctrl, wr_count;
    logic             en_bit;
    logic             t_disable;
    logic             clear_cnt, advance, load_act, wrap;
    logic             running;
    logic [WIDTH-1:0] cnt;
    logic [NUM_SHADOW-1:0] shadow_wr;
    logic [WIDTH-1:0] buf_val [NUM_SHADOW];
    logic [WIDTH-1:0] act_val [NUM_SHADOW];
    reg_sel_e         sel;

    always_comb begin
        sel      = reg_sel_e'(addr);
        wr_ctrl  = wr_en && (sel == REG_CTRL);
        wr_count = wr_en && (sel == REG_COUNT);
        en_bit   = wdata[CTRL_EN_BIT];
        shadow_wr[IDX_PERIOD] = wr_en && (sel == REG_PERIOD);
        shadow_wr[IDX_DUTY]   = wr_en && (sel == REG_DUTY);
    end

    // next state: T_ENABLE and T_DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_ctrl && en_bit)  state_d = ST_RUN;
            ST_RUN:  if (wr_ctrl && !en_bit) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_ctrl) begin
                pol_q <= wdata[CTRL_POL_BIT];
            end
        end
    end

    // per-state controls
    always_comb begin
        running   = 1'b0;
        t_disable = 1'b0;
        clear_cnt = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear_cnt = 1'b1;
            end
            ST_RUN: begin
                running   = 1'b1;
                t_disable = wr_ctrl && !en_bit;
                clear_cnt = t_disable || wr_count;
                advance   = tick && !clear_cnt;
            end
        endcase
        load_act = clear_cnt || wrap;
    end

    for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_shadow
        pwm_shadow_reg #(.WIDTH(WIDTH)) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (shadow_wr[k]),
            .wdata  (wdata),
            .load   (load_act),
            .buf_q  (buf_val[k]),
            .act_q  (act_val[k])
        );
    end

    pwm_period_counter #(.WIDTH(WIDTH)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_cnt),
        .advance (advance),
        .period  (act_val[IDX_PERIOD]),
        .cnt_q   (cnt),
        .wrap    (wrap)
    );

    pwm_level_compare #(.WIDTH(WIDTH)) u_compare (
        .running  (running),
        .polarity (pol_q),
        .cnt      (cnt),
        .duty     (act_val[IDX_DUTY]),
        .level    (pwm_out)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL:   rdata = {{(WIDTH-2){1'b0}}, pol_q, running};
            REG_PERIOD: rdata = buf_val[IDX_PERIOD];
            REG_DUTY:   rdata = buf_val[IDX_DUTY];
            REG_COUNT:  rdata = cnt;
        endcase
    end

    // R5: a counter write restarts the count
    p_count_write_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> (cnt == '0));

    // R6: an idle channel keeps its counter at zero
    p_idle_count_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (cnt == '0));

    // R3: a running channel changes its active values only at load points
    p_active_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wrap && !(wr_en && (addr == 2'd0 || addr == 2'd3)))
        |=> ($stable(act_val[IDX_DUTY]) && $stable(act_val[IDX_PERIOD])));

    // R9: an idle channel shows the polarity level
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_ctrl) |=> (pwm_out == pol_q));

endmodule

// File: tb/dbuf_pwm_channel_test.sv
`timescale 1ns/1ps
module dbuf_pwm_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    dbuf_pwm_channel #(.WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    // behavioural reference
    int m_run, m_pol, m_bper, m_bdut, m_aper, m_adut, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pol = 0; m_bper = 0; m_bdut = 0;
            m_aper = 0; m_adut = 0; m_cnt = 0;
        end else begin
            int en_n, pol_n, bp_n, bd_n, cw, ld;
            en_n = m_run; pol_n = m_pol; bp_n = m_bper; bd_n = m_bdut;
            cw = 0; ld = 0;
            if (wr_en) begin
                case (addr)
                    2'd0: begin en_n = wdata[0]; pol_n = wdata[1]; end
                    2'd1: bp_n = wdata;
                    2'd2: bd_n = wdata;
                    default: cw = 1;
                endcase
            end
            if (m_run == 0) begin
                m_cnt = 0; ld = 1;
            end else if (en_n == 0 || cw == 1) begin
                m_cnt = 0; ld = 1;
            end else if (tick) begin
                if (m_cnt + 1 >= m_aper) begin m_cnt = 0; ld = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (ld == 1) begin m_aper = bp_n; m_adut = bd_n; end
            m_run = en_n; m_pol = pol_n; m_bper = bp_n; m_bdut = bd_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_out, exp_rd;
            if (m_run == 0) exp_out = m_pol;
            else if (m_pol == 1) exp_out = (m_cnt < m_adut) ? 1 : 0;
            else exp_out = (m_cnt < m_adut) ? 0 : 1;
            case (addr)
                2'd0: exp_rd = m_pol * 2 + m_run;
                2'd1: exp_rd = m_bper;
                2'd2: exp_rd = m_bdut;
                default: exp_rd = m_cnt;
            endcase
            check(pwm_out == exp_out[0],
                  (m_run == 0) ? "R9 idle level" : ((m_pol == 1) ? "R7 level" : "R8 level"),
                  pwm_out, exp_out);
            check(rdata == exp_rd[7:0], (addr == 2'd3) ? "R4 count read" : "R2 register read",
                  rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, v;
        idle(3);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0]; #1;
            check(rdata == 8'd0, "R1 reset register", rdata, 0);
        end
        check(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R6 writes while idle apply directly; R7 high time
        wr(2'd1, 8'd10);
        wr(2'd2, 8'd3);
        wr(2'd0, 8'd3);
        count_high(10, hi);
        check(hi == 3, "R7 high time pol1", hi, 3);
        // R3 buffered duty, old waveform finishes
        wr(2'd2, 8'd7);
        addr = 2'd2; #1;
        check(rdata == 8'd7, "R2 duty read returns buffer", rdata, 7);
        idle(0);
        count_high(9, hi);
        check(hi == 2, "R3 old duty kept", hi, 2);
        count_high(10, hi);
        check(hi == 7, "R4 load at period end", hi, 7);

        // R8 polarity 0 and R5 counter write
        wr(2'd0, 8'd1);
        wr(2'd3, 8'd55);
        addr = 2'd3; #1;
        check(rdata == 8'd0, "R5 counter cleared", rdata, 0);
        count_high(10, hi);
        check(hi == 3, "R8 high time pol0", hi, 3);
        wr(2'd2, 8'd2);
        wr(2'd3, 8'd0);
        count_high(10, hi);
        check(hi == 8, "R5 counter write loads duty", hi, 8);

        // R11 no tick holds
        wr(2'd3, 8'd0);
        idle(4);
        tick = 1'b0;
        addr = 2'd3; #1;
        v = rdata;
        idle(5);
        check(rdata == v[7:0], "R11 count held", rdata, v);
        tick = 1'b1;

        // R10 extreme duty values
        wr(2'd0, 8'd3);
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd0);
        count_high(10, hi);
        check(hi == 0, "R10 duty zero", hi, 0);
        wr(2'd2, 8'd20);
        wr(2'd3, 8'd0);
        count_high(10, hi);
        check(hi == 10, "R10 duty above period", hi, 10);

        // R9 idle level, R6 disable and direct writes
        wr(2'd0, 8'd2);
        idle(3);
        check(pwm_out == 1'b1, "R9 idle shows polarity", pwm_out, 1);
        addr = 2'd3; #1;
        check(rdata == 8'd0, "R6 idle counter zero", rdata, 0);
        wr(2'd2, 8'd4);
        wr(2'd0, 8'd3);
        count_high(10, hi);
        check(hi == 4, "R6 idle write direct", hi, 4);
        wr(2'd2, 8'd6);
        wr(2'd0, 8'd2);
        wr(2'd0, 8'd3);
        count_high(10, hi);
        check(hi == 6, "R6 disable loads buffer", hi, 6);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 7) == 0) begin
                int a;
                a = $urandom_range(0, 3);
                case (a)
                    0: wr(2'd0, 8'($urandom_range(0, 3)));
                    1: wr(2'd1, 8'($urandom_range(0, 14)));
                    2: wr(2'd2, 8'($urandom_range(0, 16)));
                    default: wr(2'd3, 8'($urandom_range(0, 255)));
                endcase
            end else begin
                addr = 2'($urandom_range(0, 3));
                idle(1);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule